// File: doc/BRIEF.md
# Push-Button Deglitch and Wake Controller

This block turns a single raw push-button pin into a clean, debounced "pressed" level for a battery-management companion chip. The pin is first brought into the local clock domain by a two-flop synchroniser. A polarity setting then defines which pin level counts as active. A deglitch stage accepts a change of level only after the new level has stayed unchanged for a selectable number of slow ticks. The tick is a 1 kHz strobe, and the counts are parameters so that shortened intervals can be used in simulation.

The debounced level drives three results. The first is a level-sensitive interrupt. The second is a wake request that ends hibernate and clears the hibernate bit in the same step. The third is a sticky long-press flag, raised once the button has been held for the hold interval (8 seconds at the default parameters). Software clears this flag by writing 1. The flag cannot set again until the button has been released. Register decoding, the analog pin circuitry and the power sequencer that acts on the wake request are outside this block.

Top module: `pbtn_wake_ctrl`

## Requirements
- R1: With `cfg_enable` at 0 the button has no effect. `pressed` is forced to 0 on the cycle after enable is low, and `irq`, `wake_req` and `long_press` never rise from a press.
- R2: With `cfg_active_high` at 1 a high pin is the active level. With it at 0 a low pin is the active level. The inactive level never yields `pressed`.
- R3: `pressed` changes only on a cycle with `tick` high, and only after the synchronised active level has differed from `pressed` for FAST_TICKS ticks when `cfg_fast_deglitch` is 1, or SLOW_TICKS ticks when it is 0 (1 and 32 at the defaults).
- R4: If the synchronised level returns to the current debounced value at any time, the deglitch count restarts from zero. Pulses shorter than the selected interval are never reported.
- R5: `irq` is high exactly while `pressed` is high and `cfg_irq_en` is 1. It is a level, not a pulse.
- R6: `hib_set` sets `hibernate` when the button is not pressed. While `hibernate` is 1, a debounced press raises `wake_req`, and `hibernate` is 0 on the next cycle. A `hib_set` while the button is pressed leaves `hibernate` at 0.
- R7: `long_press` rises after `pressed` has been continuously high for HOLD_TICKS ticks (8000 at the defaults).
- R8: A one-cycle `long_clr` pulse clears `long_press`. The flag does not set again during the same press, and a later press held for HOLD_TICKS ticks sets it again.
- R9: After reset, `pressed`, `irq`, `wake_req`, `long_press` and `hibernate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow timing strobe, nominally 1 kHz |
| btn_pin | input | 1 | Raw, asynchronous push-button pin |
| cfg_enable | input | 1 | 1 enables the push-button function |
| cfg_active_high | input | 1 | 1 for active-high pin, 0 for active-low |
| cfg_fast_deglitch | input | 1 | 1 selects the short deglitch interval, 0 the long one |
| cfg_irq_en | input | 1 | Interrupt enable |
| hib_set | input | 1 | One-cycle request to enter hibernate |
| long_clr | input | 1 | One-cycle write-1-to-clear of the long-press flag |
| pressed | output | 1 | Debounced active level |
| irq | output | 1 | Level-sensitive push-button interrupt |
| wake_req | output | 1 | Wake request, high for the cycle that ends hibernate |
| hibernate | output | 1 | Hibernate bit |
| long_press | output | 1 | Sticky long-press flag |

## Verification
The assertions assume the following about the inputs:
- `tick` is a strobe that is high for one cycle at a time.
- `hib_set` and `long_clr` are single-cycle pulses.
- Configuration bits change only between test phases, while the button is inactive.

The stimulus keeps to these assumptions. It drives `tick` every fourth cycle. It changes configuration only after the debounced level has settled at released. It drives the pin only on falling clock edges, so the synchroniser always sees clean levels. Deglitch timing is checked with margins of a whole tick period on each side of the computed boundary. This allows for the unknown tick phase at the moment the pin changes.

// File: rtl/pbtn_pkg.sv
package pbtn_pkg;
    typedef struct packed {
        logic enable;
        logic active_high;
        logic fast;
        logic irq_en;
    } pbtn_cfg_t;

    function automatic logic active_level(input logic level, input logic active_high);
        return active_high ? level : ~level;
    endfunction
endpackage

// File: rtl/pbtn_sync.sv
module pbtn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.chain[STAGES-1];
endmodule

// File: rtl/pbtn_deglitch.sv
module pbtn_deglitch #(
    parameter int SLOW_TICKS = 32,
    parameter int FAST_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic fast,
    input  logic level_in,
    output logic level_out
);
    localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        logic          stable;
        logic [CW-1:0] cnt;
    } dg_t;

    dg_t           s_q, s_d;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        limit   = fast ? CW'(FAST_TICKS) : CW'(SLOW_TICKS);
        cnt_inc = s_q.cnt + CW'(1);
        s_d     = s_q;
        if (!enable) begin
            s_d = '0;
        end else if (level_in == s_q.stable) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= limit) begin
                s_d.stable = level_in;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_out = s_q.stable;
endmodule

// File: rtl/pbtn_hold_timer.sv
module pbtn_hold_timer #(
    parameter int HOLD_TICKS = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pressed,
    input  logic clr,
    output logic flag
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic          flag;
        logic          armed;
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t         s_q, s_d;
    logic          set_now;
    logic [HW-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        set_now = 1'b0;
        cnt_inc = s_q.cnt + HW'(1);
        if (!pressed) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b1;
        end else if (tick && s_q.armed) begin
            if (cnt_inc >= HW'(HOLD_TICKS)) begin
                set_now   = 1'b1;
                s_d.armed = 1'b0;
                s_d.cnt   = '0;
            end else begin
                s_d.cnt = cnt_inc;
            end
        end
        if (set_now)  s_d.flag = 1'b1;
        else if (clr) s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{flag: 1'b0, armed: 1'b1, cnt: '0};
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/pbtn_wake_ctrl.sv
module pbtn_wake_ctrl
    import pbtn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_TICKS  = 32,
    parameter int FAST_TICKS  = 1,
    parameter int HOLD_TICKS  = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_pin,
    input  logic cfg_enable,
    input  logic cfg_active_high,
    input  logic cfg_fast_deglitch,
    input  logic cfg_irq_en,
    input  logic hib_set,
    input  logic long_clr,
    output logic pressed,
    output logic irq,
    output logic wake_req,
    output logic hibernate,
    output logic long_press
);
    typedef struct packed {
        logic hib;
    } top_t;

    pbtn_cfg_t cfg;
    top_t      s_q, s_d;
    logic      pin_sync;
    logic      pin_active;
    logic      db_level;

    assign cfg = '{enable: cfg_enable, active_high: cfg_active_high,
                   fast: cfg_fast_deglitch, irq_en: cfg_irq_en};

    pbtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(btn_pin), .sync_out(pin_sync)
    );

    assign pin_active = active_level(pin_sync, cfg.active_high);

    pbtn_deglitch #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) u_dg (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(cfg.enable),
        .fast(cfg.fast), .level_in(pin_active), .level_out(db_level)
    );

    pbtn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pressed(db_level),
        .clr(long_clr), .flag(long_press)
    );

    always_comb begin
        s_d     = s_q;
        s_d.hib = (s_q.hib | hib_set) & ~db_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pressed   = db_level;
    assign irq       = db_level & cfg.irq_en;
    assign wake_req  = db_level & s_q.hib;
    assign hibernate = s_q.hib;
endmodule

// File: rtl/pbtn_wake_ctrl_checker.sv
module pbtn_wake_ctrl_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic cfg_enable,
    input logic cfg_irq_en,
    input logic hib_set,
    input logic pressed,
    input logic irq,
    input logic wake_req,
    input logic hibernate,
    input logic long_press
);
    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !pressed);

    p_change_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable) && (pressed != $past(pressed))) |-> $past(tick));

    p_irq_needs_press_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pressed && cfg_irq_en));

    p_wake_needs_hib_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> hibernate);

    p_wake_clears_hib_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !hibernate);

    p_hib_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pressed && !hibernate) |=> !hibernate);

    p_long_from_press_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_press) |-> $past(pressed));
endmodule

bind pbtn_wake_ctrl pbtn_wake_ctrl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_enable(cfg_enable),
    .cfg_irq_en(cfg_irq_en), .hib_set(hib_set), .pressed(pressed), .irq(irq),
    .wake_req(wake_req), .hibernate(hibernate), .long_press(long_press)
);

// File: tb/pbtn_wake_ctrl_test.sv
`timescale 1ns/1ps
module pbtn_wake_ctrl_test;
    localparam int TP    = 4;
    localparam int SLOW  = 8;
    localparam int FAST  = 2;
    localparam int HOLD  = 20;

    logic clk = 0, rst_n = 0, tick = 0, btn_pin = 0;
    logic cfg_enable = 0, cfg_active_high = 0, cfg_fast = 0, cfg_irq_en = 0;
    logic hib_set = 0, long_clr = 0;
    logic pressed, irq, wake_req, hibernate, long_press;
    int   n_checks = 0, n_fail = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    pbtn_wake_ctrl #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_pin(btn_pin),
        .cfg_enable(cfg_enable), .cfg_active_high(cfg_active_high),
        .cfg_fast_deglitch(cfg_fast), .cfg_irq_en(cfg_irq_en),
        .hib_set(hib_set), .long_clr(long_clr), .pressed(pressed), .irq(irq),
        .wake_req(wake_req), .hibernate(hibernate), .long_press(long_press)
    );

    initial begin
        forever begin
            repeat (TP - 1) begin @(negedge clk); tick = 0; end
            @(negedge clk); tick = 1;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_btn(input logic active);
        @(negedge clk);
        btn_pin = active ? cfg_active_high : ~cfg_active_high;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    function automatic int lim();
        return cfg_fast ? FAST : SLOW;
    endfunction

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        // R9 reset state
        chk("R9 pressed", pressed, 0);
        chk("R9 irq", irq, 0);
        chk("R9 wake_req", wake_req, 0);
        chk("R9 long_press", long_press, 0);
        chk("R9 hibernate", hibernate, 0);

        cfg_enable = 1; cfg_irq_en = 1;
        for (int pol = 0; pol < 2; pol++) begin
            for (int fs = 0; fs < 2; fs++) begin
                @(negedge clk);
                cfg_active_high = pol[0]; cfg_fast = fs[0];
                btn_pin = ~cfg_active_high;
                wait_cyc(SLOW * TP + 8);
                // R2 inactive level idle
                chk("R2 inactive level", pressed, 0);
                // R4 short pulses separated by a return to released
                begin
                    int g = (lim() - 1) * TP - 2;
                    set_btn(1); wait_cyc(g - 1);
                    set_btn(0); wait_cyc(1);
                    set_btn(1); wait_cyc(g - 1);
                    set_btn(0); wait_cyc(lim() * TP + 6);
                    chk("R4 glitch ignored", pressed, 0);
                end
                // R3 press timing
                set_btn(1);
                wait_cyc((lim() - 1) * TP - 1);
                chk("R3 before interval", pressed, 0);
                wait_cyc(TP + 7);
                chk("R3 after interval", pressed, 1);
                chk("R2 active level", pressed, 1);
                chk("R5 irq while pressed", irq, 1);
                set_btn(0);
                wait_cyc((lim() - 1) * TP - 1);
                chk("R3 release before interval", pressed, 1);
                wait_cyc(TP + 7);
                chk("R3 release after interval", pressed, 0);
                chk("R5 irq after release", irq, 0);
            end
        end

        // R7 / R8 long press, active-low fast mode
        @(negedge clk); cfg_active_high = 0; cfg_fast = 1; btn_pin = 1;
        wait_cyc(SLOW * TP + 8);
        pulse(long_clr);
        set_btn(1);
        wait_cyc(FAST * TP + 6);
        chk("R7 pressed", pressed, 1);
        wait_cyc((HOLD - 3) * TP);
        chk("R7 before hold", long_press, 0);
        wait_cyc(4 * TP + 4);
        chk("R7 after hold", long_press, 1);
        pulse(long_clr);
        chk("R8 cleared", long_press, 0);
        wait_cyc(HOLD * TP + 8);
        chk("R8 no reset in same press", long_press, 0);
        set_btn(0); wait_cyc(FAST * TP + 8);
        set_btn(1); wait_cyc(FAST * TP + 6 + HOLD * TP + 8);
        chk("R8 set on second press", long_press, 1);
        set_btn(0); wait_cyc(FAST * TP + 8);
        chk("R8 sticky after release", long_press, 1);
        pulse(long_clr);
        chk("R8 w1c", long_press, 0);

        // R5 irq disabled
        cfg_irq_en = 0;
        set_btn(1); wait_cyc(FAST * TP + 8);
        chk("R5 irq masked pressed", pressed, 1);
        chk("R5 irq masked", irq, 0);
        set_btn(0); wait_cyc(FAST * TP + 8);
        cfg_irq_en = 1;

        // R6 hibernate and wake
        pulse(hib_set);
        chk("R6 hibernate set", hibernate, 1);
        chk("R6 no wake idle", wake_req, 0);
        begin
            bit seen = 0;
            set_btn(1);
            for (int i = 0; i < FAST * TP + 10; i++) begin
                @(negedge clk);
                if (wake_req) seen = 1;
            end
            chk("R6 wake seen", seen, 1);
            chk("R6 hibernate cleared", hibernate, 0);
            chk("R6 wake is one cycle", wake_req, 0);
        end
        pulse(hib_set);
        chk("R6 hib refused while pressed", hibernate, 0);
        set_btn(0); wait_cyc(FAST * TP + 8);
        pulse(long_clr);

        // R1 disable
        @(negedge clk); cfg_enable = 0;
        pulse(hib_set);
        set_btn(1); wait_cyc(HOLD * TP + 20);
        chk("R1 pressed disabled", pressed, 0);
        chk("R1 irq disabled", irq, 0);
        chk("R1 long disabled", long_press, 0);
        chk("R1 hibernate kept", hibernate, 1);
        chk("R1 no wake", wake_req, 0);
        @(negedge clk); cfg_enable = 1;
        wait_cyc(FAST * TP + 8);
        chk("R1 pressed re-enabled", pressed, 1);
        @(negedge clk); cfg_enable = 0;
        @(negedge clk);
        chk("R1 forced release", pressed, 0);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule